// File: doc/BRIEF.md
# NAND Flash Timing-to-Cycle Converter

This block turns a set of NAND flash interface timing parameters, each given in picoseconds, into the small cycle-count fields that a bus timing sequencer consumes. It also takes the interface clock period in whole nanoseconds. Each field is derived from one parameter or from the largest of a group of parameters. The picosecond value is first truncated to nanoseconds and then divided by the clock period with rounding up. A per-field rule follows: an optional minus-one offset, an optional floor of one, and a saturating cap.

A pulse on `start` while idle launches one conversion. The six fields are produced one after another through a single shared iterative divider. `busy` is high while the conversion runs, and `done` pulses for one cycle when the last field has been written. If the timing set is too fast for the controller, or the clock period is zero, the block reports it as unsupported and leaves every field at zero. The timing inputs and clock period must be held steady from `start` until `done`.

Top module: `nand_tcyc_conv`

## Requirements
- R1: `start` in the idle state begins a conversion. `busy` is high from the cycle after `start` until `done`. `done` is high for exactly one cycle. A `start` pulse seen while busy is ignored: it neither restarts nor delays the running conversion.
- R2: When the minimum read cycle time is below 30000 ps, or the clock period is 0, the set is unsupported. In that case `done` and `unsupported` rise in the cycle after `start` and all six fields read 0. A supported set clears `unsupported`.
- R3: Every conversion is cycles(p) = ceil(floor(p / 1000) / period). The truncation to nanoseconds happens before the division by the period, so 9999 ps at 3 ns gives 3 and not 4.
- R4: `ale_gap_cyc` = cycles(address-latch-to-read-enable) − 1. A count of 0 gives 0 rather than wrapping. The result saturates at 15.
- R5: `cle_gap_cyc` follows the same rule as R4, applied to the command-latch-to-read-enable time.
- R6: `float_cyc` = cycles(max(chip-enable setup − write pulse, 0)), with no offset. It saturates at 255.
- R7: `hold_cyc` = cycles(the largest of data hold, chip-enable hold, command-latch hold, write-high hold, address-latch hold and read-high hold). A result of 0 becomes 1. It saturates at 255.
- R8: `strobe_cyc` = cycles(max(read pulse, write pulse)) − 1, clamped at 0. A result of 0 becomes 1. It saturates at 255.
- R9: `setup_cyc` = cycles(max(chip-enable setup − write pulse, chip-enable access − read access)) − 1. Each difference is clamped at 0. A result of 0 becomes 1. It saturates at 255.
- R10: While `rst_n` is low, `busy`, `done`, `unsupported` and all fields are 0. A reset during a conversion abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (accepted while idle) |
| clk_period_ns | input | 8 | Interface clock period in ns |
| rd_cycle_ps | input | 24 | Minimum read cycle time |
| ale_to_re_ps | input | 24 | Address latch to read enable delay |
| cle_to_re_ps | input | 24 | Command latch to read enable delay |
| ce_setup_ps | input | 24 | Chip enable setup time |
| we_pulse_ps | input | 24 | Write enable pulse width |
| data_hold_ps | input | 24 | Data hold time |
| ce_hold_ps | input | 24 | Chip enable hold time |
| cle_hold_ps | input | 24 | Command latch hold time |
| we_high_ps | input | 24 | Write enable high hold time |
| ale_hold_ps | input | 24 | Address latch hold time |
| re_high_ps | input | 24 | Read enable high hold time |
| re_pulse_ps | input | 24 | Read enable pulse width |
| ce_access_ps | input | 24 | Chip enable access time (maximum) |
| re_access_ps | input | 24 | Read enable access time (maximum) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when results are final |
| unsupported | output | 1 | Last timing set was rejected |
| ale_gap_cyc | output | 4 | Address-latch-to-read gap, cycles |
| cle_gap_cyc | output | 4 | Command-latch-to-read gap, cycles |
| float_cyc | output | 8 | Bus float (hi-Z) time, cycles |
| hold_cyc | output | 8 | Hold time, cycles |
| strobe_cyc | output | 8 | Strobe (wait) width, cycles |
| setup_cyc | output | 8 | Setup time, cycles |

## Verification
The converter is driven with a typical mid-speed timing set, where each field falls strictly inside its range and the max-of-group choice decides the value. A set at exactly the 30 ns read-cycle boundary has zero and negative differences, which exposes the clamp-at-zero, no-wrap and floor-of-one rules. A 1 ns clock with large times drives every field into saturation, and 16 ns lands exactly on the 4-bit cap. A 3 ns clock with values just under whole nanoseconds separates truncate-then-round from plain rounding. Two rejected sets, one a 29999 ps read cycle and one a zero clock period, check the fast reject path and the blanked fields. A mid-run `start` pulse and a mid-run reset cover the handshake.

// File: rtl/nand_tcyc_pkg.sv
package nand_tcyc_pkg;

  // Field order is the sequencing order; FLD_SETUP must stay last.
  typedef enum logic [2:0] {
    FLD_ALE    = 3'd0,
    FLD_CLE    = 3'd1,
    FLD_FLOAT  = 3'd2,
    FLD_HOLD   = 3'd3,
    FLD_STROBE = 3'd4,
    FLD_SETUP  = 3'd5
  } field_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_TO_NS  = 2'd2,
    ST_TO_CYC = 2'd3
  } state_e;

  // Per-field shaping applied to the rounded-up cycle count.
  typedef struct packed {
    logic less_one;     // subtract one, clamped at zero
    logic at_least_one; // zero becomes one
    logic narrow;       // small field, lower cap
  } rule_t;

  localparam int unsigned PS_PER_NS       = 1000;
  localparam int unsigned MIN_RD_CYCLE_PS = 30000;

endpackage

// File: rtl/nand_tcyc_div.sv
module nand_tcyc_div #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int unsigned   CW       = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] STEPS_M1 = CW'(W - 1);

  logic [W-1:0]  q_r, q_n, r_r, r_n, d_r, d_n;
  logic [CW-1:0] k_r, k_n;
  logic          run_r, run_n, fin_r, fin_n;
  logic [W:0]    trial, diff;

  // one quotient bit per cycle, restoring the remainder on a negative trial
  always_comb begin
    q_n   = q_r;
    r_n   = r_r;
    d_n   = d_r;
    k_n   = k_r;
    run_n = run_r;
    fin_n = 1'b0;
    trial = {r_r, q_r[W-1]};
    diff  = trial - {1'b0, d_r};
    if (go) begin
      q_n   = dividend;
      r_n   = '0;
      d_n   = divisor;
      k_n   = STEPS_M1;
      run_n = 1'b1;
    end else if (run_r) begin
      if (!diff[W]) begin
        r_n = diff[W-1:0];
        q_n = {q_r[W-2:0], 1'b1};
      end else begin
        r_n = trial[W-1:0];
        q_n = {q_r[W-2:0], 1'b0};
      end
      if (k_r == '0) begin
        run_n = 1'b0;
        fin_n = 1'b1;
      end else begin
        k_n = k_r - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      r_r   <= '0;
      d_r   <= '0;
      k_r   <= '0;
      run_r <= 1'b0;
      fin_r <= 1'b0;
    end else begin
      q_r   <= q_n;
      r_r   <= r_n;
      d_r   <= d_n;
      k_r   <= k_n;
      run_r <= run_n;
      fin_r <= fin_n;
    end
  end

  assign fin  = fin_r;
  assign quot = q_r;
  assign rem  = r_r;

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_r && d_r != '0) |-> (r_r < d_r));

endmodule

// File: rtl/nand_tcyc_sel.sv
module nand_tcyc_sel
  import nand_tcyc_pkg::*;
#(
  parameter int unsigned PS_W = 24
) (
  input  field_e          field,
  input  logic [PS_W-1:0] ale_to_re_ps,
  input  logic [PS_W-1:0] cle_to_re_ps,
  input  logic [PS_W-1:0] ce_setup_ps,
  input  logic [PS_W-1:0] we_pulse_ps,
  input  logic [PS_W-1:0] data_hold_ps,
  input  logic [PS_W-1:0] ce_hold_ps,
  input  logic [PS_W-1:0] cle_hold_ps,
  input  logic [PS_W-1:0] we_high_ps,
  input  logic [PS_W-1:0] ale_hold_ps,
  input  logic [PS_W-1:0] re_high_ps,
  input  logic [PS_W-1:0] re_pulse_ps,
  input  logic [PS_W-1:0] ce_access_ps,
  input  logic [PS_W-1:0] re_access_ps,
  output logic [PS_W-1:0] operand,
  output rule_t           rule
);
  function automatic logic [PS_W-1:0] sub0(input logic [PS_W-1:0] a, input logic [PS_W-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  function automatic logic [PS_W-1:0] max2(input logic [PS_W-1:0] a, input logic [PS_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [PS_W-1:0] float_ps, hold_ps, strobe_ps, setup_ps;

  always_comb begin
    float_ps  = sub0(ce_setup_ps, we_pulse_ps);
    hold_ps   = max2(max2(max2(data_hold_ps, ce_hold_ps), max2(cle_hold_ps, we_high_ps)),
                     max2(ale_hold_ps, re_high_ps));
    strobe_ps = max2(re_pulse_ps, we_pulse_ps);
    setup_ps  = max2(float_ps, sub0(ce_access_ps, re_access_ps));
    case (field)
      FLD_CLE:    begin operand = cle_to_re_ps; rule = '{1'b1, 1'b0, 1'b1}; end
      FLD_FLOAT:  begin operand = float_ps;     rule = '{1'b0, 1'b0, 1'b0}; end
      FLD_HOLD:   begin operand = hold_ps;      rule = '{1'b0, 1'b1, 1'b0}; end
      FLD_STROBE: begin operand = strobe_ps;    rule = '{1'b1, 1'b1, 1'b0}; end
      FLD_SETUP:  begin operand = setup_ps;     rule = '{1'b1, 1'b1, 1'b0}; end
      default:    begin operand = ale_to_re_ps; rule = '{1'b1, 1'b0, 1'b1}; end
    endcase
  end

endmodule

// File: rtl/nand_tcyc_conv.sv
module nand_tcyc_conv
  import nand_tcyc_pkg::*;
#(
  parameter int unsigned PS_W   = 24,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned GAP_W  = 4,
  parameter int unsigned SPAN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PER_W-1:0]  clk_period_ns,
  input  logic [PS_W-1:0]   rd_cycle_ps,
  input  logic [PS_W-1:0]   ale_to_re_ps,
  input  logic [PS_W-1:0]   cle_to_re_ps,
  input  logic [PS_W-1:0]   ce_setup_ps,
  input  logic [PS_W-1:0]   we_pulse_ps,
  input  logic [PS_W-1:0]   data_hold_ps,
  input  logic [PS_W-1:0]   ce_hold_ps,
  input  logic [PS_W-1:0]   cle_hold_ps,
  input  logic [PS_W-1:0]   we_high_ps,
  input  logic [PS_W-1:0]   ale_hold_ps,
  input  logic [PS_W-1:0]   re_high_ps,
  input  logic [PS_W-1:0]   re_pulse_ps,
  input  logic [PS_W-1:0]   ce_access_ps,
  input  logic [PS_W-1:0]   re_access_ps,
  output logic              busy,
  output logic              done,
  output logic              unsupported,
  output logic [GAP_W-1:0]  ale_gap_cyc,
  output logic [GAP_W-1:0]  cle_gap_cyc,
  output logic [SPAN_W-1:0] float_cyc,
  output logic [SPAN_W-1:0] hold_cyc,
  output logic [SPAN_W-1:0] strobe_cyc,
  output logic [SPAN_W-1:0] setup_cyc
);
  localparam logic [PS_W-1:0] GAP_CAP  = PS_W'((2 ** GAP_W) - 1);
  localparam logic [PS_W-1:0] SPAN_CAP = PS_W'((2 ** SPAN_W) - 1);
  localparam logic [PS_W-1:0] NS_DIV   = PS_W'(PS_PER_NS);
  localparam logic [PS_W-1:0] MIN_RC   = PS_W'(MIN_RD_CYCLE_PS);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  state_e            state_r, state_n;
  field_e            fld_r, fld_n;
  logic              done_r, done_n, unsup_r, unsup_n;
  logic [GAP_W-1:0]  ale_r, ale_n, cle_r, cle_n;
  logic [SPAN_W-1:0] flt_r, flt_n, hold_r, hold_n, strb_r, strb_n, setup_r, setup_n;

  logic              div_go, div_fin;
  logic [PS_W-1:0]   div_dividend, div_divisor, div_quot, div_rem;
  logic [PS_W-1:0]   operand, cyc_ceil, shaped, cap, fit;
  rule_t             rule;

  nand_tcyc_sel #(.PS_W(PS_W)) u_sel (
    .field(fld_r), .ale_to_re_ps(ale_to_re_ps), .cle_to_re_ps(cle_to_re_ps),
    .ce_setup_ps(ce_setup_ps), .we_pulse_ps(we_pulse_ps), .data_hold_ps(data_hold_ps),
    .ce_hold_ps(ce_hold_ps), .cle_hold_ps(cle_hold_ps), .we_high_ps(we_high_ps),
    .ale_hold_ps(ale_hold_ps), .re_high_ps(re_high_ps), .re_pulse_ps(re_pulse_ps),
    .ce_access_ps(ce_access_ps), .re_access_ps(re_access_ps),
    .operand(operand), .rule(rule)
  );

  nand_tcyc_div #(.W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .go(div_go), .dividend(div_dividend),
    .divisor(div_divisor), .fin(div_fin), .quot(div_quot), .rem(div_rem)
  );

  // shape the rounded-up count for the field being finished
  always_comb begin
    cyc_ceil = div_quot + PS_W'(div_rem != '0);
    if (rule.less_one) shaped = (cyc_ceil == '0) ? '0 : (cyc_ceil - PS_W'(1));
    else               shaped = cyc_ceil;
    if (rule.at_least_one && shaped == '0) shaped = PS_W'(1);
    cap = rule.narrow ? GAP_CAP : SPAN_CAP;
    fit = (shaped > cap) ? cap : shaped;
  end

  always_comb begin
    state_n = state_r;  fld_n   = fld_r;
    done_n  = 1'b0;     unsup_n = unsup_r;
    ale_n   = ale_r;    cle_n   = cle_r;   flt_n   = flt_r;
    hold_n  = hold_r;   strb_n  = strb_r;  setup_n = setup_r;
    div_go       = 1'b0;
    div_dividend = operand;
    div_divisor  = NS_DIV;
    case (state_r)
      ST_IDLE: if (start) begin
        ale_n = '0; cle_n = '0; flt_n = '0; hold_n = '0; strb_n = '0; setup_n = '0;
        if (rd_cycle_ps < MIN_RC || clk_period_ns == '0) begin
          unsup_n = 1'b1;
          done_n  = 1'b1;
        end else begin
          unsup_n = 1'b0;
          fld_n   = FLD_ALE;
          state_n = ST_LOAD;
        end
      end
      ST_LOAD: begin
        div_go  = 1'b1;
        state_n = ST_TO_NS;
      end
      ST_TO_NS: if (div_fin) begin
        div_go       = 1'b1;
        div_dividend = div_quot;
        div_divisor  = PS_W'(clk_period_ns);
        state_n      = ST_TO_CYC;
      end
      ST_TO_CYC: if (div_fin) begin
        case (fld_r)
          FLD_ALE:    ale_n   = fit[GAP_W-1:0];
          FLD_CLE:    cle_n   = fit[GAP_W-1:0];
          FLD_FLOAT:  flt_n   = fit[SPAN_W-1:0];
          FLD_HOLD:   hold_n  = fit[SPAN_W-1:0];
          FLD_STROBE: strb_n  = fit[SPAN_W-1:0];
          default:    setup_n = fit[SPAN_W-1:0];
        endcase
        if (fld_r == FLD_SETUP) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          fld_n   = field_e'(fld_r + 3'd1);
          state_n = ST_LOAD;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_r <= ST_IDLE;  fld_r  <= FLD_ALE;
      done_r  <= 1'b0;     unsup_r <= 1'b0;
      ale_r   <= '0;       cle_r  <= '0;  flt_r   <= '0;
      hold_r  <= '0;       strb_r <= '0;  setup_r <= '0;
    end else begin
      state_r <= state_n;  fld_r  <= fld_n;
      done_r  <= done_n;   unsup_r <= unsup_n;
      ale_r   <= ale_n;    cle_r  <= cle_n;  flt_r   <= flt_n;
      hold_r  <= hold_n;   strb_r <= strb_n; setup_r <= setup_n;
    end
  end

  assign busy        = (state_r != ST_IDLE);
  assign done        = done_r;
  assign unsupported = unsup_r;
  assign ale_gap_cyc = ale_r;
  assign cle_gap_cyc = cle_r;
  assign float_cyc   = flt_r;
  assign hold_cyc    = hold_r;
  assign strobe_cyc  = strb_r;
  assign setup_cyc   = setup_r;

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_r |=> !done_r);

  // R1
  busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> done_r);

  // R2
  unsup_blank_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_r && unsup_r) |-> (ale_r == '0 && cle_r == '0 && flt_r == '0 &&
                             hold_r == '0 && strb_r == '0 && setup_r == '0));

  // R7 R8 R9
  floor_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_r && !unsup_r) |-> (hold_r != '0 && strb_r != '0 && setup_r != '0));

endmodule

// File: tb/nand_tcyc_conv_test.sv
module nand_tcyc_conv_test;

  typedef struct packed {
    logic [7:0]  per;
    logic [23:0] rc, ar, clr, cs, wp, dh, ch, clh, wh, alh, reh, rp, cea, rea;
  } vec_t;

  typedef struct packed {
    logic       unsup;
    logic [3:0] ale, cle;
    logic [7:0] flt, hold, strb, setup;
  } exp_t;

  localparam int NV  = 6;
  localparam int LIM = 2000;

  localparam vec_t VECS [NV] = '{
    '{8'd10, 24'd100000, 24'd25000, 24'd20000, 24'd70000, 24'd50000, 24'd20000, 24'd20000,
      24'd20000, 24'd30000, 24'd20000, 24'd30000, 24'd50000, 24'd100000, 24'd40000},
    '{8'd10, 24'd29999, 24'd25000, 24'd20000, 24'd70000, 24'd50000, 24'd20000, 24'd20000,
      24'd20000, 24'd30000, 24'd20000, 24'd30000, 24'd50000, 24'd100000, 24'd40000},
    '{8'd10, 24'd30000, 24'd0, 24'd5000, 24'd10000, 24'd15000, 24'd0, 24'd0,
      24'd0, 24'd0, 24'd0, 24'd0, 24'd10000, 24'd25000, 24'd20000},
    '{8'd1, 24'd50000, 24'd100000, 24'd16000, 24'd400000, 24'd100000, 24'd0, 24'd0,
      24'd0, 24'd256000, 24'd0, 24'd0, 24'd256000, 24'd1000000, 24'd0},
    '{8'd0, 24'd100000, 24'd25000, 24'd20000, 24'd70000, 24'd50000, 24'd20000, 24'd20000,
      24'd20000, 24'd30000, 24'd20000, 24'd30000, 24'd50000, 24'd100000, 24'd40000},
    '{8'd3, 24'd45000, 24'd1999, 24'd3000, 24'd9999, 24'd0, 24'd0, 24'd0,
      24'd0, 24'd9999, 24'd0, 24'd0, 24'd7000, 24'd0, 24'd0}
  };

  localparam exp_t EXPS [NV] = '{
    '{1'b0, 4'd2,  4'd1,  8'd2,   8'd3,   8'd4,   8'd5},
    '{1'b1, 4'd0,  4'd0,  8'd0,   8'd0,   8'd0,   8'd0},
    '{1'b0, 4'd0,  4'd0,  8'd0,   8'd1,   8'd1,   8'd1},
    '{1'b0, 4'd15, 4'd15, 8'd255, 8'd255, 8'd255, 8'd255},
    '{1'b1, 4'd0,  4'd0,  8'd0,   8'd0,   8'd0,   8'd0},
    '{1'b0, 4'd0,  4'd0,  8'd3,   8'd3,   8'd2,   8'd2}
  };

  logic        clk, rst_n, start;
  logic [7:0]  clk_period_ns;
  logic [23:0] rd_cycle_ps, ale_to_re_ps, cle_to_re_ps, ce_setup_ps, we_pulse_ps;
  logic [23:0] data_hold_ps, ce_hold_ps, cle_hold_ps, we_high_ps, ale_hold_ps;
  logic [23:0] re_high_ps, re_pulse_ps, ce_access_ps, re_access_ps;
  logic        busy, done, unsupported;
  logic [3:0]  ale_gap_cyc, cle_gap_cyc;
  logic [7:0]  float_cyc, hold_cyc, strobe_cyc, setup_cyc;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  nand_tcyc_conv uut (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_period_ns(clk_period_ns),
    .rd_cycle_ps(rd_cycle_ps), .ale_to_re_ps(ale_to_re_ps), .cle_to_re_ps(cle_to_re_ps),
    .ce_setup_ps(ce_setup_ps), .we_pulse_ps(we_pulse_ps), .data_hold_ps(data_hold_ps),
    .ce_hold_ps(ce_hold_ps), .cle_hold_ps(cle_hold_ps), .we_high_ps(we_high_ps),
    .ale_hold_ps(ale_hold_ps), .re_high_ps(re_high_ps), .re_pulse_ps(re_pulse_ps),
    .ce_access_ps(ce_access_ps), .re_access_ps(re_access_ps),
    .busy(busy), .done(done), .unsupported(unsupported),
    .ale_gap_cyc(ale_gap_cyc), .cle_gap_cyc(cle_gap_cyc), .float_cyc(float_cyc),
    .hold_cyc(hold_cyc), .strobe_cyc(strobe_cyc), .setup_cyc(setup_cyc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R1 watchdog expired: actual=%0d cycles expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    clk_period_ns = v.per;  rd_cycle_ps  = v.rc;  ale_to_re_ps = v.ar;
    cle_to_re_ps  = v.clr;  ce_setup_ps  = v.cs;  we_pulse_ps  = v.wp;
    data_hold_ps  = v.dh;   ce_hold_ps   = v.ch;  cle_hold_ps  = v.clh;
    we_high_ps    = v.wh;   ale_hold_ps  = v.alh; re_high_ps   = v.reh;
    re_pulse_ps   = v.rp;   ce_access_ps = v.cea; re_access_ps = v.rea;
  endtask

  // launch one conversion; poke>0 pulses start again that many cycles in
  task automatic run(input vec_t v, input int poke, output int lat, output int busy0);
    @(negedge clk);
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy0 = int'(busy);
    lat = 0;
    while (!done && lat < LIM) begin
      @(negedge clk);
      lat = lat + 1;
      start = (poke > 0 && lat == poke) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
  endtask

  task automatic check_fields(input exp_t e, input int idx);
    check($sformatf("R2 unsupported flag vec %0d", idx), int'(unsupported), int'(e.unsup));
    check($sformatf("R4 ale gap vec %0d", idx), int'(ale_gap_cyc), int'(e.ale));
    check($sformatf("R5 cle gap vec %0d", idx), int'(cle_gap_cyc), int'(e.cle));
    check($sformatf("R6 float vec %0d", idx), int'(float_cyc), int'(e.flt));
    check($sformatf("R7 hold vec %0d", idx), int'(hold_cyc), int'(e.hold));
    check($sformatf("R8 strobe vec %0d", idx), int'(strobe_cyc), int'(e.strb));
    check($sformatf("R9 setup vec %0d", idx), int'(setup_cyc), int'(e.setup));
  endtask

  task automatic check_reset_state(input string tag);
    check({tag, " R10 busy"}, int'(busy), 0);
    check({tag, " R10 done"}, int'(done), 0);
    check({tag, " R10 unsupported"}, int'(unsupported), 0);
    check({tag, " R10 fields"}, int'(ale_gap_cyc) + int'(cle_gap_cyc) + int'(float_cyc)
          + int'(hold_cyc) + int'(strobe_cyc) + int'(setup_cyc), 0);
  endtask

  initial begin
    int lat_ref;
    int lat;
    int b0;
    rst_n = 1'b0;
    start = 1'b0;
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    check_reset_state("initial");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    lat_ref = 0;
    for (int i = 0; i < NV; i++) begin
      run(VECS[i], 0, lat, b0);
      check($sformatf("R1 done reached vec %0d", i), int'(lat < LIM), 1);
      if (EXPS[i].unsup) begin
        // R2: rejected sets answer in the cycle after start
        check($sformatf("R2 immediate done vec %0d", i), lat, 0);
      end else begin
        check($sformatf("R1 busy after start vec %0d", i), b0, 1);
      end
      if (i == 0) lat_ref = lat;
      check_fields(EXPS[i], i);
      @(negedge clk);
      check($sformatf("R1 done one cycle vec %0d", i), int'(done), 0);
      check($sformatf("R1 idle after done vec %0d", i), int'(busy), 0);
    end

    // R3: truncation to ns before rounding already covered by vec 5 (9999 ps at 3 ns -> 3)
    // R1: a second start while busy is ignored
    run(VECS[0], 40, lat, b0);
    check("R1 start while busy ignored (latency)", lat, lat_ref);
    check_fields(EXPS[0], 100);
    @(negedge clk);
    check("R1 no second done after ignored start", int'(done), 0);
    check("R1 idle after ignored start", int'(busy), 0);

    // R10: reset during a conversion abandons it
    @(negedge clk);
    apply(VECS[3]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("mid-run");
    rst_n = 1'b1;
    repeat (LIM / 4) @(negedge clk);
    check("R10 no done after abandoned run", int'(done), 0);
    check("R10 still idle after abandoned run", int'(busy), 0);

    // after reset the block converts normally again
    run(VECS[5], 0, lat, b0);
    check_fields(EXPS[5], 200);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule